// File: doc/BRIEF.md
# Pin Name Beacon Transmitter

A self-running asynchronous serial transmitter that drives a single output pad with a four-character ASCII name, forever. There is no data input and no control interface: the name, the system clock frequency and the baud rate are fixed when the design is elaborated. A small parameter-initialised character store feeds a shift-based transmitter, so the pad keeps announcing its own identity.

Many copies can sit side by side, one per pad, each given a different name. An engineer mapping an unknown board touches a pad with a serial adapter and reads back which pin it is. The default line rate is 9600 baud. The bit period is computed from the clock frequency parameter, not given as a raw divider.

Top module: `beacon_top`

## Requirements
- R1: While rst_ni is low, tx_o is high (idle), and it stays high until the first start bit.
- R2: Every bit lasts exactly DIV clock cycles, where DIV = round(CLK_HZ / BAUD). The counter reloads at each bit boundary, so there is no drift.
- R3: Each character is framed as 8N1. The frame is one low start bit, then eight data bits with the least significant bit first, then one high stop bit.
- R4: Characters are sent in string order. The first character is NAME[31:24], then NAME[23:16], then NAME[15:8], then NAME[7:0].
- R5: After the fourth character the sequence wraps to the first, with no end. Frames are back to back: a start bit follows the previous stop bit at once, with no extra idle time.
- R6: The first start bit begins on the first rising clock edge after rst_ni is released.
- R7: An asynchronous reset in the middle of a frame forces tx_o high at once. After release, transmission restarts from the first character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_o | output | 1 | Serial line to the pad, idle high |

## Verification
The bench decodes the line with a receiver that samples at mid-bit. It also times every start edge against the cycle count expected from DIV. With these checks, a design that rounded the divider down, or that inserted an idle bit between frames, shows up as a start edge in the wrong cycle. A design that shifted the most significant bit first, or that read the name in reverse, decodes to the wrong bytes. Resets are asserted at random points mid-stream. These catch a design that leaves the line low during reset or that resumes from a stale character index instead of the first one.

// File: rtl/beacon_pkg.sv
package beacon_pkg;
  localparam int unsigned NumChars  = 4;
  localparam int unsigned CharBits  = 8;
  localparam int unsigned FrameBits = CharBits + 2;

  // round(clk / baud) in integer arithmetic
  function automatic int unsigned bit_div(input int unsigned clk_hz, input int unsigned baud);
    return (clk_hz + baud / 2) / baud;
  endfunction
endpackage

// File: rtl/beacon_tick.sv
module beacon_tick #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] Last = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q == Last) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == Last);

  // R2: two ticks never land in adjacent cycles
  generate
    if (DIV > 1) begin : g_gap
      a_r2_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/beacon_rom.sv
module beacon_rom
  import beacon_pkg::*;
#(
  parameter logic [NumChars*CharBits-1:0] NAME = "PIN0"
) (
  input  logic [$clog2(NumChars)-1:0] addr_i,
  output logic [CharBits-1:0]         char_o
);
  logic [CharBits-1:0] mem [NumChars];

  // entry 0 is the leftmost character of the string
  generate
    for (genvar g = 0; g < NumChars; g++) begin : g_ent
      assign mem[g] = NAME[(NumChars-g)*CharBits-1 -: CharBits];
    end
  endgenerate

  assign char_o = mem[addr_i];
endmodule

// File: rtl/beacon_shift.sv
module beacon_shift
  import beacon_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tick_i,
  input  logic [CharBits-1:0]         char_i,
  output logic [$clog2(NumChars)-1:0] addr_o,
  output logic                        run_o,
  output logic                        tx_o
);
  localparam int unsigned IW = $clog2(NumChars);
  localparam int unsigned BW = $clog2(FrameBits);
  localparam logic [BW-1:0] LastBit = BW'(FrameBits - 1);

  logic                 run_q;
  logic [FrameBits-1:0] sh_q;
  logic [BW-1:0]        bit_q;
  logic [IW-1:0]        idx_q;

  // address of the character loaded next
  assign addr_o = run_q ? idx_q + 1'b1 : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      sh_q  <= '1;
      bit_q <= '0;
      idx_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
      sh_q  <= {1'b1, char_i, 1'b0};
      bit_q <= '0;
    end else if (tick_i) begin
      if (bit_q == LastBit) begin
        sh_q  <= {1'b1, char_i, 1'b0};
        bit_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        sh_q  <= {1'b1, sh_q[FrameBits-1:1]};
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign run_o = run_q;
  assign tx_o  = sh_q[0];

  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> tx_o);
  a_r3_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && bit_q == '0) |-> !tx_o);
  a_r3_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_q == LastBit) |-> tx_o);
  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && bit_q == LastBit && idx_q == IW'(NumChars-1)) |=> (idx_q == '0));
  a_r6_start_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);
endmodule

// File: rtl/beacon_top.sv
module beacon_top
  import beacon_pkg::*;
#(
  parameter int unsigned                   CLK_HZ = 25_000_000,
  parameter int unsigned                   BAUD   = 9600,
  parameter logic [NumChars*CharBits-1:0]  NAME   = "PIN0"
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tx_o
);
  localparam int unsigned DIV = bit_div(CLK_HZ, BAUD);
  localparam int unsigned IW  = $clog2(NumChars);

  logic                tick;
  logic                run;
  logic [IW-1:0]       addr;
  logic [CharBits-1:0] chr;

  beacon_tick #(.DIV(DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .tick_o(tick)
  );

  beacon_rom #(.NAME(NAME)) i_rom (
    .addr_i(addr),
    .char_o(chr)
  );

  beacon_shift i_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .char_i(chr),
    .addr_o(addr),
    .run_o (run),
    .tx_o  (tx_o)
  );
endmodule

// File: tb/test_beacon_top.sv
module test_beacon_top;
  localparam int unsigned ClkPeriod = 10;
  localparam int unsigned CLK_HZ = 1_000_000;
  localparam int unsigned BAUD   = 95_000;
  localparam logic [31:0] NAME   = "K7q2";

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx;
  int unsigned n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(ClkPeriod/2) clk = ~clk;

  beacon_top #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .NAME(NAME)) i_beacon_top (
    .clk_i(clk), .rst_ni(rst_ni), .tx_o(tx)
  );

  function automatic int unsigned exp_div();
    real r = real'(CLK_HZ) / real'(BAUD);
    return int'($floor(r + 0.5));
  endfunction

  function automatic logic [7:0] exp_char(input int unsigned k);
    return NAME[31 - 8*(k % 4) -: 8];
  endfunction

  localparam int unsigned D = 11;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  // release reset at a negedge; R6 start must be seen on the next negedge
  task automatic release_and_check_start();
    int unsigned n = 0;
    rst_ni = 1'b1;
    while (tx === 1'b1 && n < 50) begin @(negedge clk); n++; end
    check(n == 1, "R6 first start", n, 1);
  endtask

  // decode k-th char; caller sits at the negedge where the start bit first shows
  task automatic decode(input int unsigned k);
    logic [7:0] b;
    wait_n(D/2);
    check(tx == 1'b0, "R3 start bit", tx, 0);
    for (int i = 0; i < 8; i++) begin
      wait_n(D);
      b[i] = tx;
    end
    check(b == exp_char(k), "R4 char value", b, exp_char(k));
    wait_n(D);
    check(tx == 1'b1, "R3 stop bit", tx, 1);
    wait_n(10*D - (D/2 + 9*D) - 1);
    check(tx == 1'b1, "R2 stop length", tx, 1);
    wait_n(1);
    check(tx == 1'b0, "R5 back-to-back start", tx, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    check(exp_div() == D, "R2 divider", D, exp_div());
    wait_n(3);
    for (int i = 0; i < 4; i++) begin
      check(tx == 1'b1, "R1 idle in reset", tx, 1);
      wait_n(1);
    end
    release_and_check_start();
    // two full rounds, R5 wrap
    for (int k = 0; k < 8; k++) decode(k);
    // random mid-stream resets, R7
    for (int r = 0; r < 4; r++) begin
      wait_n($urandom_range(1, 3*D*10));
      rst_ni = 1'b0;
      #1;
      check(tx == 1'b1, "R7 async reset forces high", tx, 1);
      repeat ($urandom_range(1, 6)) begin
        @(negedge clk);
        check(tx == 1'b1, "R1 idle in reset", tx, 1);
      end
      release_and_check_start();
      for (int k = 0; k < 5; k++) decode(k);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule